// File: doc/BRIEF.md
# Burst Bus Cycle Controller

This block runs the external side of a 32-bit demultiplexed memory bus on behalf of a core-side requester. A request carries a word address, a byte mask, a direction, a burst length of one to four data cycles, the width of the target region (8, 16 or 32 bits) and three wait-state settings. The block then sequences one address cycle followed by the data cycles. It drives a single-cycle address strobe, a word address whose two low bits step through an aligned 16-byte block, lane selects encoded for the region width, transceiver enable and direction, a last-transfer flag and an internal-wait flag.

The programmed wait counts come first. Only after a count reaches zero does the external ready input matter, and only if ready is enabled for the request. A burst-terminate input closes the current data cycle and makes the rest of the burst start over with a fresh address cycle. A backoff input suspends the access and floats the bus. When backoff is released the access restarts with a new strobe. Once the final data cycle finishes, a programmable number of next-address idle cycles is inserted, and external inputs cannot stretch it. Read data is captured on each completed data cycle, zero-extended to the lanes the region uses, and presented with a one-cycle valid pulse.

Every bus control output is decoded from flops alone, so no input reaches an output in the same cycle.

Top module: `burst_bus_sequencer`

## Requirements
- R1: A request is accepted only while reqReady is high (idle). adsOut is high for exactly one clock per address cycle, and it is never high on two consecutive clocks. wrOut shows the request direction (1 = write) from the address cycle onward.
- R2: busAddr holds the word address. For data cycle k of a burst (k counted from 0), bits 3:2 equal the start bits 3:2 plus k, modulo 4, and the bits above stay fixed. reqBeats encodes the number of data cycles minus one.
- R3: The first data cycle after an address cycle begins with reqWaitAd internal wait clocks. Each later data cycle begins with reqWaitDd internal wait clocks. waitOut is high exactly on those clocks.
- R4: With reqReadyEn = 1, readyIn is looked at only after the internal wait count reaches zero. Each clock it is low adds one clock to the data cycle, and waitOut stays low during such added clocks.
- R5: With reqReadyEn = 0, each data cycle completes on the clock its wait count reaches zero, whatever readyIn does.
- R6: After the final data cycle the block spends reqWaitNa clocks with reqReady, adsOut and denOut low before it becomes idle. readyIn and btermIn have no effect on the length of this period.
- R7: When reqReadyEn = 1 and btermIn is high on a data-cycle clock after the wait count has expired, that data cycle completes. readyIn is ignored on that clock. If data cycles remain, a new address cycle with adsOut high follows, and the next data cycle then uses the reqWaitAd count.
- R8: blastOut is high on every clock of the final data cycle once its wait count is zero, and it stays high until that cycle completes.
- R9: busBe is encoded by region width (reqWidth 0 = 8-bit, 1 = 16-bit, 2 = 32-bit). For 32-bit it equals the byte mask. For 16-bit it is {high enable, 0, A1, low enable}: A1 = 0 with the enables taken from mask bits 1:0 when either of those bits is set, otherwise A1 = 1 with the enables taken from mask bits 3:2. For 8-bit it is {2'b00, index of the lowest set mask bit}.
- R10: denOut is high on every data-cycle clock and low on address, next-address, idle and backoff clocks. dtrOut is 1 for a read (receive) and 0 for a write, and it changes only when denOut is low on both the current and the previous clock.
- R11: When boffIn is high at a clock edge during an address or data cycle, the block enters backoff: busFloat goes high and adsOut, denOut and blastOut go low. Backoff takes priority over a completing ready, and the interrupted data cycle does not complete. On the first clock after boffIn is seen low, adsOut is high and the interrupted data cycle is repeated.
- R12: For a read, every completed data cycle produces exactly one rdValid pulse on the next clock. rdData carries busDataIn masked to lanes 7:0 for an 8-bit region, lanes 15:0 for a 16-bit region, and all 32 lanes for a 32-bit region, with the upper bits zero. A write produces no rdValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqWordAddr | input | ADDR_W-2 | Word address of the first data cycle |
| reqByteMask | input | 4 | Bytes of the word to access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data, driven for the whole access |
| reqBeats | input | BEAT_W | Number of data cycles minus one |
| reqWidth | input | 2 | Region width: 0 = 8, 1 = 16, 2 = 32 bits |
| reqWaitAd | input | WAIT_W | Wait clocks before the first data cycle after an address cycle |
| reqWaitDd | input | WAIT_W | Wait clocks before each later data cycle |
| reqWaitNa | input | WAIT_W | Idle clocks after the final data cycle |
| reqReadyEn | input | 1 | Enables readyIn and btermIn for this request |
| busAddr | output | ADDR_W-2 | Word address on the bus |
| busBe | output | 4 | Lane selects, encoded per region width |
| adsOut | output | 1 | Address strobe |
| wrOut | output | 1 | Direction of the access, 1 = write |
| blastOut | output | 1 | Final transfer flag |
| waitOut | output | 1 | Internal wait counter is inserting waits |
| denOut | output | 1 | Transceiver enable (data cycle) |
| dtrOut | output | 1 | Transceiver direction, 1 = receive |
| busFloat | output | 1 | Bus outputs released during backoff |
| busDataOut | output | 32 | Write data lanes |
| busDataIn | input | 32 | Read data lanes |
| readyIn | input | 1 | External ready |
| btermIn | input | 1 | Burst terminate |
| boffIn | input | 1 | Backoff |
| rdData | output | 32 | Captured read data, lane-masked |
| rdValid | output | 1 | rdData valid pulse |

## Verification
The hardest situation to reach from the ports is a backoff that lands on the very clock a ready would have completed a data cycle, because the interrupted cycle must be dropped and replayed after a new strobe. The stimulus uses zero wait states, so the first data clock already has ready granted, and it raises backoff on that same clock. The read scoreboard then shows that no extra or out-of-order data word appears. Burst terminate is produced by a responder that counts the ready grants it issues and turns one chosen grant into a terminate. The responder also withholds ready for a set number of clocks after the internal wait flag drops, so that an extension can be told apart from the programmed waits.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [1:0] {
    WID8  = 2'd0,
    WID16 = 2'd1,
    WID32 = 2'd2
  } regionWidth_e;

  typedef struct packed {
    logic loadReq;   // latch a new request
    logic advance;   // step to the next data cycle of the burst
    logic capture;   // a data cycle completes this clock
  } ctrlStrobe_t;

  function automatic logic [3:0] laneSelect(regionWidth_e width, logic [3:0] mask);
    logic [1:0] idx;
    logic [3:0] sel;
    idx = mask[0] ? 2'd0 : mask[1] ? 2'd1 : mask[2] ? 2'd2 : 2'd3;
    case (width)
      WID8:    sel = {2'b00, idx};
      WID16:   sel = (|mask[1:0]) ? {mask[1], 1'b0, 1'b0, mask[0]}
                                  : {mask[3], 1'b0, 1'b1, mask[2]};
      default: sel = mask;
    endcase
    return sel;
  endfunction

  function automatic logic [31:0] laneMask(regionWidth_e width, logic [31:0] d);
    logic [31:0] r;
    case (width)
      WID8:    r = {24'd0, d[7:0]};
      WID16:   r = {16'd0, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
  import bbs_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [WAIT_W-1:0] reqWaitAd,
  input  logic [WAIT_W-1:0] reqWaitDd,
  input  logic [WAIT_W-1:0] reqWaitNa,
  input  logic              reqReadyEn,
  input  logic              readyIn,
  input  logic              btermIn,
  input  logic              boffIn,
  output logic              reqReady,
  output logic              adsOut,
  output logic              denOut,
  output logic              blastOut,
  output logic              waitOut,
  output logic              busFloat,
  output ctrlStrobe_t       strobe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_NXA,
    ST_BACK
  } busState_e;

  busState_e         state, nState;
  logic [WAIT_W-1:0] cnt, nCnt;
  logic [BEAT_W-1:0] beatsLeft, nLeft;
  logic [WAIT_W-1:0] waitAd, waitDd, waitNa;
  logic              readyEn;
  logic              terminate, beatDone;

  assign terminate = readyEn && btermIn;
  assign beatDone  = (state == ST_DATA) && (cnt == '0) && !boffIn &&
                     (!readyEn || readyIn || terminate);

  always_comb begin
    strobe = '0;
    nState = state;
    nCnt   = cnt;
    nLeft  = beatsLeft;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          nLeft          = reqBeats;
          nState         = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (boffIn) begin
          nState = ST_BACK;
        end else begin
          nState = ST_DATA;
          nCnt   = waitAd;
        end
      end
      ST_DATA: begin
        if (boffIn) begin
          nState = ST_BACK;
        end else if (cnt != '0) begin
          nCnt = cnt - 1'b1;
        end else if (beatDone) begin
          strobe.capture = 1'b1;
          if (beatsLeft == '0) begin
            if (waitNa == '0) begin
              nState = ST_IDLE;
            end else begin
              nState = ST_NXA;
              nCnt   = waitNa - 1'b1;
            end
          end else begin
            strobe.advance = 1'b1;
            nLeft          = beatsLeft - 1'b1;
            if (terminate) begin
              nState = ST_ADDR;
            end else begin
              nCnt = waitDd;
            end
          end
        end
      end
      ST_NXA: begin
        if (cnt == '0) nState = ST_IDLE;
        else           nCnt   = cnt - 1'b1;
      end
      ST_BACK: begin
        if (!boffIn) nState = ST_ADDR;
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      beatsLeft <= '0;
      waitAd    <= '0;
      waitDd    <= '0;
      waitNa    <= '0;
      readyEn   <= 1'b0;
    end else begin
      state     <= nState;
      cnt       <= nCnt;
      beatsLeft <= nLeft;
      if (strobe.loadReq) begin
        waitAd  <= reqWaitAd;
        waitDd  <= reqWaitDd;
        waitNa  <= reqWaitNa;
        readyEn <= reqReadyEn;
      end
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign adsOut   = (state == ST_ADDR);
  assign denOut   = (state == ST_DATA);
  assign waitOut  = (state == ST_DATA) && (cnt != '0);
  assign blastOut = (state == ST_DATA) && (cnt == '0) && (beatsLeft == '0);
  assign busFloat = (state == ST_BACK);

  // R1: the strobe never lasts two clocks
  assert_ads_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    adsOut |=> !adsOut);

  // R3: an internally counted wait is always followed by a data clock or backoff
  assert_wait_then_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    waitOut |=> (denOut || busFloat));

  // R8: the final-transfer flag holds while ready is withheld
  assert_blast_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (blastOut && readyEn && !readyIn && !btermIn && !boffIn) |=> blastOut);

  // R11: release of backoff is followed by a fresh strobe
  assert_resume_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busFloat) |-> adsOut);

endmodule

// File: rtl/bbs_dpath.sv
module bbs_dpath
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:2] reqWordAddr,
  input  logic [3:0]        reqByteMask,
  input  logic              reqWrite,
  input  logic [1:0]        reqWidth,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       busDataIn,
  output logic [ADDR_W-1:2] busAddr,
  output logic [3:0]        busBe,
  output logic              wrOut,
  output logic              dtrOut,
  output logic [31:0]       busDataOut,
  output logic [31:0]       rdData,
  output logic              rdValid
);

  localparam int OFS_HI = BEAT_W + 1;

  logic [ADDR_W-1:OFS_HI+1] addrHi;
  logic [BEAT_W-1:0]        beatOfs;
  regionWidth_e             widthReg;

  assign busAddr = {addrHi, beatOfs};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHi     <= '0;
      beatOfs    <= '0;
      busBe      <= '0;
      widthReg   <= WID32;
      wrOut      <= 1'b0;
      dtrOut     <= 1'b0;
      busDataOut <= '0;
      rdData     <= '0;
      rdValid    <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        addrHi     <= reqWordAddr[ADDR_W-1:OFS_HI+1];
        beatOfs    <= reqWordAddr[OFS_HI:2];
        busBe      <= laneSelect(regionWidth_e'(reqWidth), reqByteMask);
        widthReg   <= regionWidth_e'(reqWidth);
        wrOut      <= reqWrite;
        dtrOut     <= !reqWrite;
        busDataOut <= reqWdata;
      end else if (strobe.advance) begin
        beatOfs <= beatOfs + 1'b1;
      end
      rdValid <= strobe.capture && !wrOut;
      if (strobe.capture && !wrOut) rdData <= laneMask(widthReg, busDataIn);
    end
  end

  // R12: a byte-wide region never returns data above lane 7
  assert_rd_lanes_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && widthReg == WID8) |-> (rdData[31:8] == '0));

endmodule

// File: rtl/burst_bus_sequencer.sv
module burst_bus_sequencer
  import bbs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WAIT_W    = 4,
  parameter int MAX_BEATS = 4,
  localparam int BEAT_W   = $clog2(MAX_BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:2] reqWordAddr,
  input  logic [3:0]        reqByteMask,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [1:0]        reqWidth,
  input  logic [WAIT_W-1:0] reqWaitAd,
  input  logic [WAIT_W-1:0] reqWaitDd,
  input  logic [WAIT_W-1:0] reqWaitNa,
  input  logic              reqReadyEn,
  output logic [ADDR_W-1:2] busAddr,
  output logic [3:0]        busBe,
  output logic              adsOut,
  output logic              wrOut,
  output logic              blastOut,
  output logic              waitOut,
  output logic              denOut,
  output logic              dtrOut,
  output logic              busFloat,
  output logic [31:0]       busDataOut,
  input  logic [31:0]       busDataIn,
  input  logic              readyIn,
  input  logic              btermIn,
  input  logic              boffIn,
  output logic [31:0]       rdData,
  output logic              rdValid
);

  ctrlStrobe_t strobe;

  bbs_ctrl #(.WAIT_W(WAIT_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBeats(reqBeats),
    .reqWaitAd(reqWaitAd), .reqWaitDd(reqWaitDd), .reqWaitNa(reqWaitNa),
    .reqReadyEn(reqReadyEn), .readyIn(readyIn), .btermIn(btermIn), .boffIn(boffIn),
    .reqReady(reqReady), .adsOut(adsOut), .denOut(denOut), .blastOut(blastOut),
    .waitOut(waitOut), .busFloat(busFloat), .strobe(strobe)
  );

  bbs_dpath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWordAddr(reqWordAddr),
    .reqByteMask(reqByteMask), .reqWrite(reqWrite), .reqWidth(reqWidth),
    .reqWdata(reqWdata), .busDataIn(busDataIn), .busAddr(busAddr), .busBe(busBe),
    .wrOut(wrOut), .dtrOut(dtrOut), .busDataOut(busDataOut), .rdData(rdData),
    .rdValid(rdValid)
  );

  // R10: transceiver direction moves only with the enable off on both clocks
  assert_dtr_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dtrOut) |-> (!denOut && !$past(denOut)));

  // R11: strobes stay off while the bus is released
  assert_float_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    busFloat |-> (!adsOut && !denOut && !blastOut));

endmodule

// File: tb/burst_bus_sequencer_tb.sv
module burst_bus_sequencer_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady;
  logic [31:2] reqWordAddr = '0;
  logic [3:0]  reqByteMask = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [1:0]  reqBeats = '0, reqWidth = 2'd2;
  logic [3:0]  reqWaitAd = '0, reqWaitDd = '0, reqWaitNa = '0;
  logic        reqReadyEn = 1'b0;
  logic [31:2] busAddr;
  logic [3:0]  busBe;
  logic        adsOut, wrOut, blastOut, waitOut, denOut, dtrOut, busFloat;
  logic [31:0] busDataOut, busDataIn, rdData;
  logic        readyIn = 1'b0, btermIn = 1'b0, boffIn = 1'b0;
  logic        rdValid;

  assign busDataIn = {~busAddr[17:2], busAddr[17:2]};

  burst_bus_sequencer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWordAddr(reqWordAddr), .reqByteMask(reqByteMask), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .reqBeats(reqBeats), .reqWidth(reqWidth),
    .reqWaitAd(reqWaitAd), .reqWaitDd(reqWaitDd), .reqWaitNa(reqWaitNa),
    .reqReadyEn(reqReadyEn), .busAddr(busAddr), .busBe(busBe), .adsOut(adsOut),
    .wrOut(wrOut), .blastOut(blastOut), .waitOut(waitOut), .denOut(denOut),
    .dtrOut(dtrOut), .busFloat(busFloat), .busDataOut(busDataOut),
    .busDataIn(busDataIn), .readyIn(readyIn), .btermIn(btermIn), .boffIn(boffIn),
    .rdData(rdData), .rdValid(rdValid)
  );

  int nCompared = 0, nMismatched = 0;
  logic [31:0] expQ[$];

  // responder and monitor configuration
  int   cfgExtend = 0, cfgBterm = -1, ext = 0, grant = 0, boffAge = 0;
  logic cfgRen = 1'b1, cfgBoff = 1'b0, boffDone = 1'b0;
  int   adsCnt = 0, waitCnt = 0, blastCnt = 0, floatCnt = 0;
  logic denSeen = 1'b0, beFirstDtr = 1'b0, wrFirst = 1'b0;
  logic [3:0] beFirst = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expData(input logic [29:0] w, input logic [1:0] width);
    logic [31:0] full;
    full = {~w[15:0], w[15:0]};
    case (width)
      2'd0:    return {24'd0, full[7:0]};
      2'd1:    return {16'd0, full[15:0]};
      default: return full;
    endcase
  endfunction

  // monitor, ready responder, backoff generator and scoreboard consumer
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12 unexpected rdValid", rdData, 0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(rdData == e, "R2/R12 read data", rdData, e);
        end
      end
      adsCnt   += int'(adsOut);
      waitCnt  += int'(waitOut);
      blastCnt += int'(blastOut);
      floatCnt += int'(busFloat);
      if (adsOut && adsCnt == 1) begin beFirst = busBe; wrFirst = wrOut; end
      if (denOut && !denSeen) begin beFirstDtr = dtrOut; denSeen = 1'b1; end
      if (denOut && !waitOut) begin
        if (ext < cfgExtend) begin
          readyIn = 1'b0; btermIn = 1'b0; ext++;
        end else begin
          readyIn = cfgRen; btermIn = cfgRen && (grant == cfgBterm);
          grant++; ext = 0;
        end
      end else begin
        readyIn = 1'b0; btermIn = 1'b0; ext = 0;
      end
      if (boffIn) begin
        boffAge++;
        if (boffAge == 3) boffIn = 1'b0;
      end else if (cfgBoff && denOut && !boffDone) begin
        boffIn = 1'b1; boffAge = 0; boffDone = 1'b1;
      end
    end
  end

  task automatic runAccess(input logic [31:0] byteAddr, input logic [3:0] mask,
                           input logic wr, input int beats, input logic [1:0] width,
                           input int wad, input int wdd, input int wna,
                           input logic ren, input int extend, input int btermAt,
                           input logic boffOn, input int expLen, input string tag);
    int len;
    logic [29:0] w;
    w = byteAddr[31:2];
    if (!wr) begin
      for (int k = 0; k < beats; k++) begin
        logic [29:0] wk;
        wk = {w[29:2], w[1:0] + 2'(k)};
        expQ.push_back(expData(wk, width));
      end
    end
    cfgExtend = extend; cfgBterm = btermAt; cfgRen = ren; cfgBoff = boffOn;
    boffDone = 1'b0; grant = 0; ext = 0;
    adsCnt = 0; waitCnt = 0; blastCnt = 0; floatCnt = 0; denSeen = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWordAddr = w; reqByteMask = mask; reqWrite = wr;
    reqWdata = 32'hA5C3_0F96; reqBeats = 2'(beats - 1); reqWidth = width;
    reqWaitAd = 4'(wad); reqWaitDd = 4'(wdd); reqWaitNa = 4'(wna); reqReadyEn = ren;
    @(negedge clk);
    reqValid = 1'b0;
    len = 0;
    while (!reqReady) begin len++; @(negedge clk); end
    @(negedge clk);
    if (expLen >= 0) check(len == expLen, {tag, " access length"}, len, expLen);
    check(expQ.size() == 0, "R12 all reads returned", expQ.size(), 0);
    check(wrFirst == wr, "R1 direction at strobe", wrFirst, wr);
    check(beFirstDtr == !wr, "R10 transceiver direction", beFirstDtr, !wr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !adsOut && !denOut && !blastOut && !waitOut && !busFloat,
          "R1 reset state", {reqReady, adsOut, denOut, blastOut, waitOut, busFloat}, 6'b100000);

    // single 32-bit read, two address-to-data waits
    runAccess(32'h0000_1234, 4'hF, 1'b0, 1, 2'd2, 2, 0, 0, 1'b1, 0, -1, 1'b0, 4, "R3");
    check(waitCnt == 2, "R3 wait clocks", waitCnt, 2);
    check(adsCnt == 1, "R1 one strobe", adsCnt, 1);
    check(blastCnt == 1, "R8 last flag clocks", blastCnt, 1);

    // 4-beat wrapping burst with ready held off two clocks per beat
    runAccess(32'h0000_0108, 4'hF, 1'b0, 4, 2'd2, 1, 1, 1, 1'b1, 2, -1, 1'b0, 18, "R2/R4/R6");
    check(waitCnt == 4, "R4 wait flag only for counted waits", waitCnt, 4);
    check(blastCnt == 3, "R8 last flag held through extension", blastCnt, 3);

    // ready disabled: completes on count expiry, ready never given
    runAccess(32'h0000_0020, 4'hF, 1'b0, 2, 2'd2, 3, 2, 0, 1'b0, 5, -1, 1'b0, 8, "R5");
    check(waitCnt == 5, "R5 wait clocks", waitCnt, 5);

    // write with three next-address clocks that ready low cannot stretch
    runAccess(32'h0000_0040, 4'h6, 1'b1, 1, 2'd2, 0, 0, 3, 1'b1, 0, -1, 1'b0, 5, "R6");
    check(beFirst == 4'b0110, "R9 32-bit lanes", beFirst, 4'b0110);

    // burst terminate on the first data cycle of three
    runAccess(32'h0000_0200, 4'hF, 1'b0, 3, 2'd2, 1, 0, 0, 1'b1, 0, 0, 1'b0, 7, "R7");
    check(adsCnt == 2, "R7 new strobe after terminate", adsCnt, 2);
    check(waitCnt == 2, "R7 address-to-data count reused", waitCnt, 2);

    // lane encodings per width
    runAccess(32'h0000_0300, 4'b1100, 1'b0, 1, 2'd1, 0, 0, 0, 1'b1, 0, -1, 1'b0, 2, "R9");
    check(beFirst == 4'b1011, "R9 16-bit upper half", beFirst, 4'b1011);
    runAccess(32'h0000_0304, 4'b0001, 1'b1, 1, 2'd1, 0, 0, 0, 1'b1, 0, -1, 1'b0, 2, "R9");
    check(beFirst == 4'b0001, "R9 16-bit lower half", beFirst, 4'b0001);
    runAccess(32'h0000_0308, 4'b1000, 1'b0, 1, 2'd0, 0, 0, 0, 1'b1, 0, -1, 1'b0, 2, "R9");
    check(beFirst == 4'b0011, "R9 8-bit byte 3", beFirst, 4'b0011);
    runAccess(32'h0000_030C, 4'b0100, 1'b0, 1, 2'd0, 0, 0, 0, 1'b1, 0, -1, 1'b0, 2, "R9");
    check(beFirst == 4'b0010, "R9 8-bit byte 2", beFirst, 4'b0010);

    // backoff on the clock ready would complete the first data cycle
    runAccess(32'h0000_0400, 4'hF, 1'b0, 2, 2'd2, 0, 0, 0, 1'b1, 0, -1, 1'b1, -1, "R11");
    check(floatCnt == 3, "R11 float clocks", floatCnt, 3);
    check(adsCnt == 2, "R11 strobe on resume", adsCnt, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nCompared++; nMismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule